// File: doc/BRIEF.md
# Core-Local Timer and Software-Interrupt Unit

This block gives a single hart its machine timer and its machine software interrupt. It holds three pieces of state: a one-bit software-interrupt pending flag, a 64-bit compare value and a 64-bit free-running time count. Software reaches this state through a small register bus. Each request carries an address, a byte width, a read/write flag and write data. The response comes back in the same cycle, as read data or as an access fault.

The time count advances by one after a configurable number of tick-enable pulses. This lets the platform tie timer progress to retired instructions or to any other pacing event. The timer-interrupt line is raised whenever the time count has reached the compare value. The software-interrupt line reflects the pending flag directly.

Only exact, aligned accesses at three fixed offsets are accepted. Every other access reports a fault. A read that is not accepted raises the load fault and a write that is not accepted raises the store fault. A rejected write leaves all state unchanged.

Top module: `hart_timer_unit`

## Requirements
- R1: After reset the pending flag is 0, the time count is 0, the compare value is all ones, and both interrupt outputs are 0.
- R2: A read at offset 0x0000 with width 4 or 8 returns the pending flag in bit 0, with bits 63:1 zero, and raises no fault.
- R3: A write at offset 0x0000 with width 4 or 8 sets the pending flag to bit 0 of the write data from the next cycle on. Bits 63:1 of the write data are ignored. The software-interrupt output equals the pending flag.
- R4: An 8-byte write at offset 0x4000 loads all 64 bits of the compare value without a fault. An 8-byte read at 0x4000 returns the compare value.
- R5: An 8-byte read at offset 0xBFF8 returns the full 64-bit time count without a fault.
- R6: The time count rises by exactly 1 on the clock edge that ends every TICK_DIV-th cycle with tickEn high, counted since reset. Cycles with tickEn low leave the time count and the pulse count unchanged.
- R7: The timer-interrupt output is 1 exactly when the time count is greater than or equal to the compare value, compared as unsigned numbers. It follows the register values in the same cycle.
- R8: Any other read raises rspLoadFault and returns zero read data, without raising rspStoreFault. This covers widths other than 4/8 at 0x0000, widths other than 8 at 0x4000 and 0xBFF8, offsets 0x4004 and 0xBFFC, and every other address.
- R9: Any other write raises rspStoreFault without raising rspLoadFault, and changes no state. This covers every write at 0xBFF8, width-4 writes at 0x4000, and the unsupported offsets and widths.
- R10: While reqValid is 0, neither fault is raised, the read data is zero, and no request input changes any state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Pacing pulse for the time count prescaler |
| reqValid | input | 1 | A request is presented this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte offset inside the unit |
| reqWidth | input | 4 | Access size in bytes |
| reqWdata | input | 64 | Write data |
| rspRdata | output | 64 | Read data, valid in the request cycle |
| rspLoadFault | output | 1 | Read request was rejected |
| rspStoreFault | output | 1 | Write request was rejected |
| swIrq | output | 1 | Machine software interrupt |
| timerIrq | output | 1 | Machine timer interrupt |

## Verification
The bench programs the compare value a few ticks ahead of the time count and runs the count across it. A comparator that is strict or signed would miss the equal cycle, or would fire straight after reset against the all-ones value. It probes the neighbour offsets 0x4004 and 0xBFFC, width-4 accesses to the 64-bit registers, and every write to the time count. A decoder that matched loosely would return data or update state there instead of faulting. It also writes the pending offset with upper data bits set and bit 0 clear, and sends writes with reqValid low, so that a design that ignores bit selection or the valid qualifier shows a wrong pending flag when it is read back.

// File: rtl/hart_timer_pkg.sv
package hart_timer_pkg;

  localparam logic [15:0] SOFT_OFS = 16'h0000;
  localparam logic [15:0] CMP_OFS  = 16'h4000;
  localparam logic [15:0] TIME_OFS = 16'hBFF8;

  localparam int DATA_W = 64;

  // strobes from decode control to the register datapath
  typedef struct packed {
    logic wrSoft;
    logic wrCmp;
    logic rdSoft;
    logic rdCmp;
    logic rdTime;
  } htuStrobe_t;

endpackage

// File: rtl/htu_ctrl.sv
module htu_ctrl
  import hart_timer_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqWidth,
  output htuStrobe_t        strobe,
  output logic              loadFault,
  output logic              storeFault
);

  logic hitSoft, hitCmp, hitTime;
  logic readOk, writeOk;
  logic isRead, isWrite;

  always_comb begin
    hitSoft = (reqAddr == ADDR_W'(SOFT_OFS)) && (reqWidth == 4'd4 || reqWidth == 4'd8);
    hitCmp  = (reqAddr == ADDR_W'(CMP_OFS))  && (reqWidth == 4'd8);
    hitTime = (reqAddr == ADDR_W'(TIME_OFS)) && (reqWidth == 4'd8);
    readOk  = hitSoft | hitCmp | hitTime;
    writeOk = hitSoft | hitCmp;
    isRead  = reqValid & ~reqWrite;
    isWrite = reqValid &  reqWrite;
  end

  always_comb begin
    strobe.wrSoft = isWrite & hitSoft;
    strobe.wrCmp  = isWrite & hitCmp;
    strobe.rdSoft = isRead  & hitSoft;
    strobe.rdCmp  = isRead  & hitCmp;
    strobe.rdTime = isRead  & hitTime;
    loadFault     = isRead  & ~readOk;
    storeFault    = isWrite & ~writeOk;
  end

  AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(loadFault && storeFault)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (strobe == '0 && !loadFault && !storeFault)); // R10
  AST_WRITE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrSoft, strobe.wrCmp, storeFault})); // R9
  AST_READ_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.rdSoft, strobe.rdCmp, strobe.rdTime, loadFault})); // R8

endmodule

// File: rtl/htu_datapath.sv
module htu_datapath
  import hart_timer_pkg::*;
#(
  parameter int TICK_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  htuStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              softPend,
  output logic              timerHit
);

  logic [DATA_W-1:0] cmpReg;
  logic [DATA_W-1:0] timeReg;
  logic              stepNow;

  generate
    if (TICK_DIV > 1) begin : gPre
      localparam int PRE_W = $clog2(TICK_DIV);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN) preCnt <= '0;
        else if (tickEn) preCnt <= (preCnt == PRE_LAST) ? '0 : preCnt + 1'b1;
      end
      assign stepNow = tickEn && (preCnt == PRE_LAST);
    end else begin : gNoPre
      assign stepNow = tickEn;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      softPend <= 1'b0;
      cmpReg   <= '1;
      timeReg  <= '0;
    end else begin
      if (strobe.wrSoft) softPend <= wrData[0];
      if (strobe.wrCmp)  cmpReg   <= wrData;
      if (stepNow)       timeReg  <= timeReg + 1'b1;
    end
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdSoft)      rdData = {{(DATA_W-1){1'b0}}, softPend};
    else if (strobe.rdCmp)  rdData = cmpReg;
    else if (strobe.rdTime) rdData = timeReg;
  end

  assign timerHit = (timeReg >= cmpReg);

  AST_SOFT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrSoft |=> softPend == $past(wrData[0])); // R3
  AST_SOFT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrSoft |=> $stable(softPend)); // R9
  AST_CMP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrCmp |=> cmpReg == $past(wrData)); // R4
  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrCmp |=> $stable(cmpReg)); // R9
  AST_TIME_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(timeReg)); // R6
  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> (timeReg == $past(timeReg) || timeReg == $past(timeReg) + 64'd1)); // R6

endmodule

// File: rtl/hart_timer_unit.sv
module hart_timer_unit
  import hart_timer_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int TICK_DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [3:0]        reqWidth,
  input  logic [63:0]       reqWdata,
  output logic [63:0]       rspRdata,
  output logic              rspLoadFault,
  output logic              rspStoreFault,
  output logic              swIrq,
  output logic              timerIrq
);

  htuStrobe_t strobe;

  htu_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqWidth  (reqWidth),
    .strobe    (strobe),
    .loadFault (rspLoadFault),
    .storeFault(rspStoreFault)
  );

  htu_datapath #(.TICK_DIV(TICK_DIV)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .strobe  (strobe),
    .wrData  (reqWdata),
    .rdData  (rspRdata),
    .softPend(swIrq),
    .timerHit(timerIrq)
  );

  AST_FAULT_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rspLoadFault |-> rspRdata == 64'd0); // R8
  AST_SOFT_READ_ZX: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqAddr == ADDR_W'(SOFT_OFS) && !rspLoadFault)
      |-> rspRdata[63:1] == 63'd0); // R2

endmodule

// File: tb/tb_hart_timer_unit.sv
module tb_hart_timer_unit;

  localparam int TDIV = 3;

  logic        clk = 1'b0;
  logic        rstN;
  logic        tickEn;
  logic        reqValid, reqWrite;
  logic [15:0] reqAddr;
  logic [3:0]  reqWidth;
  logic [63:0] reqWdata;
  logic [63:0] rspRdata;
  logic        rspLoadFault, rspStoreFault, swIrq, timerIrq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model state
  logic [63:0] mTime, mCmp;
  logic        mSoft;
  int          mPre;

  always #5 clk = ~clk;

  hart_timer_unit #(.ADDR_W(16), .TICK_DIV(TDIV)) dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWidth(reqWidth), .reqWdata(reqWdata), .rspRdata(rspRdata),
    .rspLoadFault(rspLoadFault), .rspStoreFault(rspStoreFault),
    .swIrq(swIrq), .timerIrq(timerIrq)
  );

  function automatic bit okSoft(input logic [15:0] a, input logic [3:0] w);
    return a == 16'h0000 && (w == 4'd4 || w == 4'd8);
  endfunction
  function automatic bit okCmp(input logic [15:0] a, input logic [3:0] w);
    return a == 16'h4000 && w == 4'd8;
  endfunction
  function automatic bit okTime(input logic [15:0] a, input logic [3:0] w);
    return a == 16'hBFF8 && w == 4'd8;
  endfunction

  function automatic logic [63:0] expRd(input bit v, input bit wr,
                                        input logic [15:0] a, input logic [3:0] w);
    if (!v || wr) return 64'd0;
    if (okSoft(a, w)) return {63'd0, mSoft};
    if (okCmp(a, w))  return mCmp;
    if (okTime(a, w)) return mTime;
    return 64'd0;
  endfunction

  function automatic string rdTag(input logic [15:0] a, input logic [3:0] w);
    if (okSoft(a, w)) return "R2";
    if (okCmp(a, w))  return "R4";
    if (okTime(a, w)) return "R5";
    return "R8";
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doCycle(input bit v, input bit wr, input logic [15:0] a,
                         input logic [3:0] w, input logic [63:0] d, input bit te);
    bit eLf, eSf;
    @(negedge clk);
    reqValid = v; reqWrite = wr; reqAddr = a; reqWidth = w; reqWdata = d; tickEn = te;
    #1;
    eLf = v && !wr && !(okSoft(a, w) || okCmp(a, w) || okTime(a, w));
    eSf = v && wr && !(okSoft(a, w) || okCmp(a, w));
    chk(v ? rdTag(a, w) : "R10", rspRdata, expRd(v, wr, a, w));
    chk(v ? "R8" : "R10", {63'd0, rspLoadFault}, {63'd0, eLf});
    chk(v ? "R9" : "R10", {63'd0, rspStoreFault}, {63'd0, eSf});
    chk("R3", {63'd0, swIrq}, {63'd0, mSoft});
    chk("R7", {63'd0, timerIrq}, {63'd0, mTime >= mCmp});
    @(posedge clk);
    if (v && wr && okSoft(a, w)) mSoft = d[0];
    if (v && wr && okCmp(a, w))  mCmp = d;
    if (te) begin
      if (mPre == TDIV - 1) begin mPre = 0; mTime = mTime + 64'd1; end
      else mPre = mPre + 1;
    end
  endtask

  task automatic readTime(input string tag);
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = 16'hBFF8; reqWidth = 4'd8; tickEn = 0;
    #1;
    chk(tag, rspRdata, mTime);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] addrPool [6];
    logic [3:0]  widthPool [4];
    void'($urandom(32'd20240611));
    addrPool[0] = 16'h0000; addrPool[1] = 16'h4000; addrPool[2] = 16'hBFF8;
    addrPool[3] = 16'h4004; addrPool[4] = 16'hBFFC; addrPool[5] = 16'h0004;
    widthPool[0] = 4'd1; widthPool[1] = 4'd2; widthPool[2] = 4'd4; widthPool[3] = 4'd8;

    rstN = 0; tickEn = 0; reqValid = 0; reqWrite = 0;
    reqAddr = '0; reqWidth = '0; reqWdata = '0;
    mTime = 0; mCmp = '1; mSoft = 0; mPre = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1: reset state
    #1;
    chk("R1", {63'd0, swIrq}, 64'd0);
    chk("R1", {63'd0, timerIrq}, 64'd0);
    readTime("R1");
    doCycle(1, 0, 16'h4000, 4'd8, 0, 0); // R1 compare all ones

    // R3/R2: soft flag write width 4, read width 8; upper bits ignored
    doCycle(1, 1, 16'h0000, 4'd4, 64'h1, 0);
    doCycle(1, 0, 16'h0000, 4'd8, 0, 0);
    doCycle(1, 1, 16'h0000, 4'd8, 64'hFFFF_FFFF_FFFF_FFFE, 0);
    doCycle(1, 0, 16'h0000, 4'd4, 0, 0);

    // R10: idle with write-looking inputs changes nothing
    doCycle(0, 1, 16'h0000, 4'd8, 64'h1, 0);
    doCycle(0, 1, 16'h4000, 4'd8, 64'h0, 0);
    doCycle(1, 0, 16'h0000, 4'd8, 0, 0);
    doCycle(1, 0, 16'h4000, 4'd8, 0, 0);

    // R9: faulting writes leave state
    doCycle(1, 1, 16'hBFF8, 4'd8, 64'h1234, 0);
    doCycle(1, 1, 16'h4000, 4'd4, 64'h0, 0);
    doCycle(1, 1, 16'h4004, 4'd4, 64'h0, 0);
    doCycle(1, 1, 16'h0000, 4'd2, 64'h1, 0);
    readTime("R9");
    doCycle(1, 0, 16'h4000, 4'd8, 0, 0);
    doCycle(1, 0, 16'h0000, 4'd8, 0, 0);

    // R8: faulting reads
    doCycle(1, 0, 16'h4000, 4'd4, 0, 0);
    doCycle(1, 0, 16'hBFFC, 4'd4, 0, 0);
    doCycle(1, 0, 16'hBFF8, 4'd4, 0, 0);
    doCycle(1, 0, 16'h0000, 4'd1, 0, 0);

    // R4/R6/R7: compare a few steps ahead, run the count across it
    doCycle(1, 1, 16'h4000, 4'd8, mTime + 64'd3, 0);
    for (int i = 0; i < 5 * TDIV; i++) doCycle(0, 0, 16'h0, 4'd0, 0, 1);
    readTime("R6");
    doCycle(1, 1, 16'h4000, 4'd8, mTime, 0); // equal case
    doCycle(1, 1, 16'h4000, 4'd8, 64'h8000_0000_0000_0000, 0); // unsigned
    for (int i = 0; i < 7; i++) doCycle(0, 0, 16'h0, 4'd0, 0, (i % 2) == 0);
    readTime("R6");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      logic [3:0]  w;
      logic [63:0] d;
      a = ($urandom % 8 < 6) ? addrPool[$urandom % 6] : 16'($urandom);
      w = ($urandom % 4 == 0) ? 4'($urandom) : widthPool[$urandom % 4];
      d = {$urandom, $urandom};
      if (a == 16'h4000 && $urandom % 2 == 0) d = mTime + 64'($urandom % 6);
      doCycle($urandom % 4 != 0, $urandom % 2 == 1, a, w, d, $urandom % 3 != 0);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule